// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration image into a target FPGA through a slave-serial port that behaves like SPI. After a start pulse it takes the image a byte at a time over a valid/ready handshake. It asserts an active-low select and shifts each byte out on a single data line, most significant bit first, against a clock that it generates itself. The target captures data on the rising clock edge.

When the last bit has gone out, the select is released and the sequencer keeps sending slow clock pulses. After each pulse it looks at the target's done input, which it first passes through a two-flop synchroniser. A watchdog counts from the moment the select is released. If done is seen, a fixed burst of extra pulses follows and the block reports success. If the watchdog runs out first, the block stops and reports failure. The pulse half-period and the timeout are set in microseconds and milliseconds and are converted to system clock counts from the clock frequency parameter.

Top module: `cfg_stream_loader`

## Requirements
- R1: Out of reset, cs_n_o and sclk_o are high, and busy_o, ok_o, fail_o and byte_ready_o are low.
- R2: A start accepted while idle drives cs_n_o low on the next cycle. cs_n_o stays low until the final data bit's high clock phase ends, then returns high. It is high whenever the block is idle.
- R3: Every byte goes out most significant bit first. The data line is updated only together with a falling clock and stays stable for the whole high phase, so each bit is valid at the rising edge.
- R4: The clock rests high between bytes and after the final data bit. byte_ready_o is asserted only while the clock is high, the select is low and a whole number of bytes (a multiple of 8 bits) has been sent.
- R5: Exactly img_len_i bytes are accepted through the handshake and exactly 8 × img_len_i rising edges occur with the select low. A valid byte may be held back for any number of cycles.
- R6: After the select is released, every low phase and every high phase of the clock lasts HALF_US microseconds, expressed in system clock cycles. The synchronised done input is sampled at the end of each high phase.
- R7: Once done has been sampled high on pulse k, exactly TAIL_PULSES further pulses follow (k + TAIL_PULSES rising edges after release). ok_o is then set and busy_o cleared, with the clock high.
- R8: If done has not been seen within TIMEOUT_MS milliseconds of cycles counted from the select's release, busy_o drops exactly that many cycles after the release and fail_o is set. The clock is left high and the select stays high.
- R9: A start pulse while busy_o is high is ignored: the running byte count and the sequence are not disturbed.
- R10: ok_o and fail_o are never both high. Each holds its value while idle until the next accepted start, which clears both on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load (taken only while idle) |
| img_len_i | input | LEN_W | Number of image bytes, sampled at start |
| byte_valid_i | input | 1 | Image byte available |
| byte_ready_o | output | 1 | Sequencer takes the byte this cycle |
| byte_data_i | input | 8 | Image byte |
| cs_n_o | output | 1 | Active-low select to the target |
| sclk_o | output | 1 | Configuration clock |
| sdata_o | output | 1 | Configuration data line |
| cdone_i | input | 1 | Target's done flag (asynchronous) |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load completed |
| fail_o | output | 1 | Last load timed out |

## Verification
The assertions check on every cycle that the select is high whenever the block is idle, and that data holds while the clock stays high. They also check that a byte is requested only with the clock high inside the data phase, that the remaining byte count never grows during a load, and that the result flags are exclusive, hold while idle and leave the bus parked. Only the bench scenarios can show the things that need a count over a whole load. These are the bit order of each captured byte, the number of bytes accepted, the exact width of every slow clock phase, the number of trailing pulses after done, and the exact number of cycles between release and timeout.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_BIT_LO,
    ST_BIT_HI,
    ST_POLL_LO,
    ST_POLL_HI,
    ST_TAIL_LO,
    ST_TAIL_HI
  } ld_state_e;
endpackage

// File: rtl/cfg_sync2.sv
module cfg_sync2 (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic ff1_q, ff2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= d_i;
      ff2_q <= ff1_q;
    end
  end
  assign q_o = ff2_q;
endmodule

// File: rtl/cfg_phase_timer.sv
// Counts cycles spent in one clock phase; expire_o marks the last cycle.
module cfg_phase_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  assign expire_o = (cnt_q == limit_i - W'(1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clear_i || expire_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/cfg_watchdog.sv
// Runs while run_i is high, restarts from zero whenever it is low.
module cfg_watchdog #(
  parameter int unsigned LIMIT = 1000,
  localparam int unsigned W = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  logic [W-1:0] cnt_q;
  assign expire_o = run_i && (cnt_q == W'(LIMIT - 1));
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!run_i)                    cnt_q <= '0;
    else if (cnt_q != W'(LIMIT - 1))    cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfg_loader_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 250_000_000,
  parameter int unsigned HALF_US       = 100,
  parameter int unsigned TIMEOUT_MS    = 2000,
  parameter int unsigned DATA_HALF_CYC = 2,
  parameter int unsigned TAIL_PULSES   = 50,
  parameter int unsigned LEN_W         = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] img_len_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic [7:0]       byte_data_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdata_o,
  input  logic             cdone_i,
  output logic             busy_o,
  output logic             ok_o,
  output logic             fail_o
);
  localparam longint unsigned HALF64 = (64'(CLK_HZ) * 64'(HALF_US)) / 64'd1_000_000;
  localparam longint unsigned TMO64  = (64'(CLK_HZ) * 64'(TIMEOUT_MS)) / 64'd1_000;
  localparam int unsigned HALF_CYC = int'(HALF64);
  localparam int unsigned TMO_CYC  = int'(TMO64);
  localparam int unsigned PH_MAX   = (HALF_CYC > DATA_HALF_CYC) ? HALF_CYC : DATA_HALF_CYC;
  localparam int unsigned PH_W     = $clog2(PH_MAX + 1);
  localparam int unsigned TAIL_W   = $clog2(TAIL_PULSES + 1);

  ld_state_e         state_q, state_d;
  logic [7:0]        shreg_q, shreg_d;
  logic [2:0]        bit_q, bit_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [TAIL_W-1:0] tail_q, tail_d;
  logic              sclk_q, sclk_d, cs_n_q, cs_n_d, sdata_q, sdata_d;
  logic              ok_q, ok_d, fail_q, fail_d;

  logic            done_s, tmr_exp, wdg_exp, in_data, in_poll;
  logic [PH_W-1:0] tmr_lim;

  cfg_sync2 u_done_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cdone_i),
    .q_o    (done_s)
  );

  assign in_data = (state_q == ST_BIT_LO) || (state_q == ST_BIT_HI);
  assign in_poll = (state_q == ST_POLL_LO) || (state_q == ST_POLL_HI);
  assign tmr_lim = in_data ? PH_W'(DATA_HALF_CYC) : PH_W'(HALF_CYC);

  cfg_phase_timer #(.W(PH_W)) u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_d != state_q),
    .limit_i  (tmr_lim),
    .expire_o (tmr_exp)
  );

  cfg_watchdog #(.LIMIT(TMO_CYC)) u_wdg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_poll),
    .expire_o (wdg_exp)
  );

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    bit_d   = bit_q;
    left_d  = left_q;
    tail_d  = tail_q;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    sdata_d = sdata_q;
    ok_d    = ok_q;
    fail_d  = fail_q;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        ok_d   = 1'b0;
        fail_d = 1'b0;
        left_d = img_len_i;
        if (img_len_i == '0) begin
          sclk_d  = 1'b0;
          state_d = ST_POLL_LO;
        end else begin
          cs_n_d  = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: if (byte_valid_i) begin
        shreg_d = byte_data_i;
        sdata_d = byte_data_i[7];
        bit_d   = '0;
        sclk_d  = 1'b0;
        state_d = ST_BIT_LO;
      end
      ST_BIT_LO: if (tmr_exp) begin
        sclk_d  = 1'b1;
        state_d = ST_BIT_HI;
      end
      ST_BIT_HI: if (tmr_exp) begin
        if (bit_q == 3'd7) begin
          left_d = left_q - LEN_W'(1);
          if (left_q == LEN_W'(1)) begin
            cs_n_d  = 1'b1;
            sclk_d  = 1'b0;
            state_d = ST_POLL_LO;
          end else begin
            state_d = ST_FETCH;
          end
        end else begin
          bit_d   = bit_q + 3'd1;
          shreg_d = {shreg_q[6:0], 1'b0};
          sdata_d = shreg_q[6];
          sclk_d  = 1'b0;
          state_d = ST_BIT_LO;
        end
      end
      ST_POLL_LO: begin
        if (wdg_exp) begin
          fail_d  = 1'b1;
          sclk_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_exp) begin
          sclk_d  = 1'b1;
          state_d = ST_POLL_HI;
        end
      end
      ST_POLL_HI: begin
        if (tmr_exp && done_s) begin
          tail_d  = '0;
          sclk_d  = 1'b0;
          state_d = ST_TAIL_LO;
        end else if (wdg_exp) begin
          fail_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_exp) begin
          sclk_d  = 1'b0;
          state_d = ST_POLL_LO;
        end
      end
      ST_TAIL_LO: if (tmr_exp) begin
        sclk_d  = 1'b1;
        state_d = ST_TAIL_HI;
      end
      ST_TAIL_HI: if (tmr_exp) begin
        if (tail_q == TAIL_W'(TAIL_PULSES - 1)) begin
          ok_d    = 1'b1;
          state_d = ST_IDLE;
        end else begin
          tail_d  = tail_q + TAIL_W'(1);
          sclk_d  = 1'b0;
          state_d = ST_TAIL_LO;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      left_q  <= '0;
      tail_q  <= '0;
      sclk_q  <= 1'b1;
      cs_n_q  <= 1'b1;
      sdata_q <= 1'b0;
      ok_q    <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      left_q  <= left_d;
      tail_q  <= tail_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      sdata_q <= sdata_d;
      ok_q    <= ok_d;
      fail_q  <= fail_d;
    end
  end

  assign byte_ready_o = (state_q == ST_FETCH);
  assign busy_o       = (state_q != ST_IDLE);
  assign cs_n_o       = cs_n_q;
  assign sclk_o       = sclk_q;
  assign sdata_o      = sdata_q;
  assign ok_o         = ok_q;
  assign fail_o       = fail_q;

  a_r2_cs_high_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_n_o);
  a_r3_data_held_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(sdata_o));
  a_r4_request_on_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> sclk_o && !cs_n_o);
  a_r9_count_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> left_q <= $past(left_q));
  a_r10_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fail_o));
  a_r10_ok_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(ok_o) && !$past(start_i) |-> ok_o);
  a_r7_ok_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> !busy_o && sclk_o && cs_n_o);
  a_r8_fail_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !busy_o && sclk_o && cs_n_o);
endmodule

// File: tb/cfg_stream_loader_bench.sv
`timescale 1ns/1ps
module cfg_stream_loader_bench;
  localparam int unsigned CLK_HZ   = 50_000;
  localparam int unsigned HALF_US  = 100;
  localparam int unsigned TMO_MS   = 4;
  localparam int unsigned DHALF    = 2;
  localparam int unsigned TAIL     = 50;
  localparam int unsigned LEN_W    = 8;
  localparam int HALF_EXP = CLK_HZ * HALF_US / 1_000_000;  // 5 cycles
  localparam int TMO_EXP  = CLK_HZ * TMO_MS / 1_000;        // 200 cycles

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, valid = 1'b0, cdone = 1'b0;
  logic [LEN_W-1:0] img_len = '0;
  logic [7:0] data = '0;
  logic ready, cs_n, sclk, sdata, busy, ok, fail;

  always #2 clk = ~clk;

  cfg_stream_loader #(
    .CLK_HZ(CLK_HZ), .HALF_US(HALF_US), .TIMEOUT_MS(TMO_MS),
    .DATA_HALF_CYC(DHALF), .TAIL_PULSES(TAIL), .LEN_W(LEN_W)
  ) u_cfg_stream_loader (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .img_len_i(img_len),
    .byte_valid_i(valid), .byte_ready_o(ready), .byte_data_i(data),
    .cs_n_o(cs_n), .sclk_o(sclk), .sdata_o(sdata), .cdone_i(cdone),
    .busy_o(busy), .ok_o(ok), .fail_o(fail)
  );

  int checks = 0, errors = 0;
  logic [7:0] img [0:31];
  logic [7:0] cap [0:31];
  int idx, bitcnt, post_rises, post_cycles, cdone_at, cur_len;
  int width_err, ready_err, csn_err, last_edge, cyc;
  bit xfer_pend, post_prev, src_en, gaps, prev_sclk = 1'b1, done_flag = 1'b0;

  task automatic chk(input bit cond, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Byte source and target-side monitor, all at the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (xfer_pend) begin idx++; xfer_pend = 1'b0; end
    data  = img[idx];
    valid = src_en && (!gaps || (cyc % 7) < 3);
    if (valid && ready) xfer_pend = 1'b1;
    if (ready && (!sclk || cs_n || (bitcnt % 8) != 0)) ready_err++;
    if (busy && cs_n && bitcnt < 8 * cur_len) csn_err++;
    if (sclk != prev_sclk) begin
      if (post_prev && busy && (cyc - last_edge) != HALF_EXP) width_err++;
      last_edge = cyc;
      post_prev = cs_n && busy;
      if (sclk) begin
        if (!cs_n) begin
          cap[bitcnt / 8] = {cap[bitcnt / 8][6:0], sdata};
          bitcnt++;
        end else if (busy) post_rises++;
      end
    end
    prev_sclk = sclk;
    if (cs_n && busy) post_cycles++;
    if (cdone_at != 0 && post_rises >= cdone_at) cdone = 1'b1;
    if (cyc > 150_000 && !done_flag) begin
      done_flag = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150_000);
      finish_run();
    end
  end

  task automatic start_load(input int len, input int done_at, input bit gap);
    idx = 0; bitcnt = 0; post_rises = 0; post_cycles = 0;
    width_err = 0; ready_err = 0; csn_err = 0; post_prev = 1'b0; xfer_pend = 1'b0;
    for (int i = 0; i < 32; i++) cap[i] = 8'h00;
    cdone = 1'b0; cdone_at = done_at; gaps = gap; src_en = 1'b1; cur_len = len;
    @(negedge clk);
    start = 1'b1; img_len = LEN_W'(len);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 20_000) begin @(negedge clk); n++; end
    chk(!busy, "R7", "load finished", busy, 0);
    src_en = 1'b0;
  endtask

  task automatic check_load(input string tag, input int len, input int done_at);
    for (int i = 0; i < len; i++)
      chk(cap[i] == img[i], "R3", {tag, " byte MSB first"}, cap[i], img[i]);
    chk(idx == len, "R5", {tag, " bytes accepted"}, idx, len);
    chk(bitcnt == 8 * len, "R5", {tag, " data edges"}, bitcnt, 8 * len);
    chk(csn_err == 0, "R2", {tag, " select early release"}, csn_err, 0);
    chk(ready_err == 0, "R4", {tag, " request timing"}, ready_err, 0);
    chk(width_err == 0, "R6", {tag, " slow phase width"}, width_err, 0);
    chk(post_rises == done_at + TAIL, "R7", {tag, " pulses after release"},
        post_rises, done_at + TAIL);
    chk(ok && !fail, "R7", {tag, " ok flag"}, ok, 1);
    chk(cs_n && sclk, "R4", {tag, " bus parked high"}, {cs_n, sclk}, 3);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cs_n && sclk, "R1", "reset cs_n/sclk", {cs_n, sclk}, 3);
    chk(!busy && !ok && !fail && !ready, "R1", "reset flags",
        {busy, ok, fail, ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_basic();
    img[0] = 8'hA5; img[1] = 8'h3C; img[2] = 8'h01;
    start_load(3, 3, 1'b0);
    chk(!cs_n && busy, "R2", "select low after start", cs_n, 0);
    wait_idle();
    check_load("basic", 3, 3);
  endtask

  task automatic t_gaps();
    img[0] = 8'hFF; img[1] = 8'h00; img[2] = 8'h80; img[3] = 8'h7F; img[4] = 8'hC3;
    start_load(5, 1, 1'b1);
    wait_idle();
    check_load("gapped", 5, 1);
  endtask

  task automatic t_start_busy();
    img[0] = 8'h96; img[1] = 8'h5A;
    start_load(2, 2, 1'b0);
    repeat (40) @(negedge clk);
    start = 1'b1; img_len = LEN_W'(7);
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    chk(idx == 2, "R9", "start while busy ignored", idx, 2);
    check_load("busy-start", 2, 2);
  endtask

  task automatic t_hold_ok();
    repeat (30) @(negedge clk);
    chk(ok && !fail, "R10", "ok holds while idle", ok, 1);
    img[0] = 8'h11;
    start_load(1, 4, 1'b0);
    chk(!ok && busy, "R10", "ok cleared by start", ok, 0);
    wait_idle();
    check_load("single", 1, 4);
  endtask

  task automatic t_timeout();
    img[0] = 8'hE7;
    start_load(1, 0, 1'b0);
    wait_idle();
    chk(fail && !ok, "R8", "fail flag", fail, 1);
    chk(post_cycles == TMO_EXP, "R8", "timeout cycles", post_cycles, TMO_EXP);
    chk(cs_n && sclk, "R8", "bus parked after fail", {cs_n, sclk}, 3);
    chk(width_err == 0, "R6", "poll phase width", width_err, 0);
    repeat (20) @(negedge clk);
    chk(fail, "R10", "fail holds while idle", fail, 1);
    img[0] = 8'h42;
    start_load(1, 2, 1'b0);
    chk(!fail, "R10", "fail cleared by start", fail, 0);
    wait_idle();
    check_load("after-fail", 1, 2);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) img[i] = 8'h00;
    src_en = 1'b0; gaps = 1'b0; cdone_at = 0; cur_len = 0;
    t_reset();
    t_basic();
    t_gaps();
    t_start_busy();
    t_hold_ok();
    t_timeout();
    done_flag = 1'b1;
    finish_run();
  end
endmodule